// File: doc/BRIEF.md
# Two-Level LRU Bus Arbiter

This block is the central arbiter of a shared parallel bus on which every transfer is preceded by a request/grant handshake. Each master raises its own request line, and the arbiter answers with a one-hot grant vector. A per-master group bit places every master in either a favoured group or a background group. The favoured group is ordered least-recently-used. The whole background group takes a single place in that order, and inside the background group its members are ordered least-recently-used among themselves. With n favoured masters and all masters requesting, the background group wins one start in every n+1.

The grant is evaluated again on every clock, including while the bus is busy. The next master can therefore be chosen during the current transfer with no idle cycle lost to arbitration. A grant does not give ownership: the newly granted master waits until the bus goes idle before it starts. The arbiter treats a transfer as started by the granted master on the cycle the bus changes from idle to busy, and it updates its recency order only at that moment. The arbiter leaves reset switched off and issues no grant until the off bit is cleared through a one-cycle configuration write.

Top module: `two_level_lru_arbiter`

## Requirements
- R1: After reset the off bit is 1 and `gnt` is all zeros. A write (`cfg_we`=1 with `cfg_dis`=0) is captured at a rising edge. The earliest edge that can raise a grant is the next rising edge after that one.
- R2: `gnt` is a register. It is at most one-hot on every cycle and is recomputed at every rising edge from the inputs sampled at that edge.
- R3: A grant goes only to a master whose `req` bit was 1 at the deciding edge. If no `req` bit is set, `gnt` keeps its previous value (parking), and it stays zero if nothing has been granted since the arbiter was switched on.
- R4: Arbitration also runs while `bus_busy` is 1. The grant can move from one master to another at a single edge with no all-zero cycle in between.
- R5: A start event is a rising edge at which `bus_busy` is 1, the controller was in state IDLE and `gnt` is nonzero. Only at a start event does the granted master become most recently used. Decisions at that same edge still use the order from before the update.
- R6: The favoured order has MASTERS+1 places: master indices 0..MASTERS-1, then a place for the background group. At reset the order runs from least to most recent in that sequence, so index 0 is least recent and the group place is most recent. The eligible place that is least recent wins.
- R7: The background order covers indices 0..MASTERS-1, with index 0 least recent at reset. When the group place wins, the least recent requesting background master is granted. A start by a background master makes both that master and the group place most recent.
- R8: With two favoured and two background masters all requesting, 12 back-to-back transfers give each favoured master 4 starts and each background master 2 starts.
- R9: `grp_low[i]`=1 puts master i in the background group. A change applies at the next edge that decides a grant, even in the middle of a transfer, and never produces two grants at once.
- R10: A write of `cfg_dis`=1 drops `gnt` to zero at the edge after the write edge. The controller then stays in state OFF.
- R11: If all masters share one group, or if exactly one master is in the background group, every master gets an equal share of starts under plain LRU rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | MASTERS | Request line of each master |
| bus_busy | input | 1 | Bus busy (frame or ready of the current initiator active) |
| grp_low | input | MASTERS | Group bit of each master; 1 selects the background group |
| cfg_we | input | 1 | One-cycle write strobe for the off bit |
| cfg_dis | input | 1 | Value written to the off bit; 1 switches the arbiter off |
| gnt | output | MASTERS | One-hot grant vector, or all zeros |

## Verification
The controller states are OFF (no grants), IDLE (switched on, bus idle) and BUSY (switched on, bus busy). OFF goes to IDLE or BUSY once the off bit is clear, IDLE goes to BUSY when the bus becomes busy, and BUSY goes back to IDLE when it becomes idle. Any state goes to OFF while the off bit is set. A start event, which updates the recency order, and a hidden handover to the next master fall at the same edge. The bench provokes this by keeping every request high while it raises `bus_busy`. It then judges the edge against a reference model built on queues. That model arbitrates with the order from before the update and only then moves the owner to the back of its queue, so if the RTL used the updated order a cycle early, the grant would disagree from that edge on. Group bits and requests are also changed while a transfer is in flight, so that a regrouping meets an in-flight handover.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_BUSY = 2'd2
    } arb_state_e;
endpackage

// File: rtl/lru_order.sv
// Recency order over ENTRIES places, kept as a pairwise "i older than j" matrix.
module lru_order #(
    parameter int ENTRIES = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] elig,
    input  logic               use_en,
    input  logic [ENTRIES-1:0] use_vec,
    output logic [ENTRIES-1:0] win
);
    logic [ENTRIES-1:0][ENTRIES-1:0] older_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                for (int j = 0; j < ENTRIES; j++) begin
                    older_q[i][j] <= 1'(i < j);
                end
            end
        end else if (use_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                for (int j = 0; j < ENTRIES; j++) begin
                    if (i != j) begin
                        if (use_vec[i]) begin
                            older_q[i][j] <= 1'b0;
                        end else if (use_vec[j]) begin
                            older_q[i][j] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_win
        logic beats_all;
        always_comb begin
            beats_all = 1'b1;
            for (int j = 0; j < ENTRIES; j++) begin
                if (j != gi && elig[j] && !older_q[gi][j]) begin
                    beats_all = 1'b0;
                end
            end
        end
        assign win[gi] = elig[gi] & beats_all;
    end
endmodule

// File: rtl/two_level_lru_arbiter.sv
module two_level_lru_arbiter
    import arb_pkg::*;
#(
    parameter int MASTERS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MASTERS-1:0] req,
    input  logic               bus_busy,
    input  logic [MASTERS-1:0] grp_low,
    input  logic               cfg_we,
    input  logic               cfg_dis,
    output logic [MASTERS-1:0] gnt
);
    localparam int HI_PLACES = MASTERS + 1;
    localparam int GRP_SLOT  = MASTERS;

    arb_state_e         state, state_nx;
    logic               dis_q;
    logic [MASTERS-1:0] lo_elig, lo_win, pick;
    logic [HI_PLACES-1:0] hi_elig, hi_win, hi_use;
    logic               start_ev, owner_low, any_req;

    // Off bit: set by reset, written by a one-cycle strobe.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q <= 1'b1;
        end else if (cfg_we) begin
            dis_q <= cfg_dis;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  state_nx = dis_q ? ST_OFF : (bus_busy ? ST_BUSY : ST_IDLE);
            ST_IDLE: state_nx = dis_q ? ST_OFF : (bus_busy ? ST_BUSY : ST_IDLE);
            ST_BUSY: state_nx = dis_q ? ST_OFF : (bus_busy ? ST_BUSY : ST_IDLE);
            default: state_nx = ST_OFF;
        endcase
    end

    // Candidate sets for both levels.
    assign lo_elig  = req & grp_low;
    assign hi_elig  = {|lo_elig, req & ~grp_low};
    assign any_req  = |req;

    assign start_ev  = (state == ST_IDLE) && bus_busy && (|gnt);
    assign owner_low = |(gnt & grp_low);
    assign hi_use    = owner_low ? {1'b1, {MASTERS{1'b0}}} : {1'b0, gnt};

    lru_order #(.ENTRIES(HI_PLACES)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (hi_elig),
        .use_en  (start_ev),
        .use_vec (hi_use),
        .win     (hi_win)
    );

    lru_order #(.ENTRIES(MASTERS)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (lo_elig),
        .use_en  (start_ev && owner_low),
        .use_vec (gnt),
        .win     (lo_win)
    );

    assign pick = hi_win[GRP_SLOT] ? lo_win : hi_win[MASTERS-1:0];

    // Output register: re-arbitrated every edge, parked when nobody asks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt <= '0;
        end else if (dis_q) begin
            gnt <= '0;
        end else if (any_req) begin
            gnt <= pick;
        end
    end
endmodule

// File: rtl/arb_checker.sv
module arb_checker
    import arb_pkg::*;
#(
    parameter int MASTERS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [MASTERS-1:0] req,
    input logic [MASTERS-1:0] gnt,
    input logic               dis_q,
    input arb_state_e         state
);
    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R2
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> (gnt == '0)); // R1
    AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        dis_q |=> (gnt == '0)); // R10
    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_q && req == '0) |=> $stable(gnt)); // R3
    AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis_q && req != '0) |=> ((gnt & $past(req)) != '0)); // R3
endmodule

bind two_level_lru_arbiter arb_checker #(.MASTERS(MASTERS)) u_arb_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .gnt   (gnt),
    .dis_q (dis_q),
    .state (state)
);

// File: tb/tb_two_level_lru_arbiter.sv
module tb_two_level_lru_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         bus_busy = 1'b0;
    logic [N-1:0] grp_low = '0;
    logic         cfg_we = 1'b0;
    logic         cfg_dis = 1'b0;
    logic [N-1:0] gnt;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_req = "R1";
    int    starts[N];

    // Reference model state
    logic [N-1:0] exp_gnt = '0;
    int m_dis = 1;
    int m_st = 0;          // 0 off, 1 idle, 2 busy
    int hi_q[$];
    int lo_q[$];

    two_level_lru_arbiter #(.MASTERS(N)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .bus_busy(bus_busy),
        .grp_low(grp_low), .cfg_we(cfg_we), .cfg_dis(cfg_dis), .gnt(gnt)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic void to_back(ref int q[$], input int v);
        for (int i = 0; i < q.size(); i++) begin
            if (q[i] == v) begin
                q.delete(i);
                break;
            end
        end
        q.push_back(v);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dis = 1; m_st = 0; exp_gnt = '0;
            hi_q = {};
            lo_q = {};
            for (int i = 0; i <= N; i++) hi_q.push_back(i);
            for (int i = 0; i < N; i++) lo_q.push_back(i);
        end else begin
            logic [N-1:0] ng;
            logic [N-1:0] lo_e;
            int h;
            int l;
            bit st;
            lo_e = req & grp_low;
            ng = exp_gnt;
            if (m_dis != 0) ng = '0;
            else if (req != '0) begin
                h = -1;
                foreach (hi_q[k]) begin
                    if (h < 0) begin
                        if (hi_q[k] == N) begin
                            if (lo_e != '0) h = N;
                        end else if (req[hi_q[k]] && !grp_low[hi_q[k]]) h = hi_q[k];
                    end
                end
                if (h == N) begin
                    l = -1;
                    foreach (lo_q[k]) if (l < 0 && lo_e[lo_q[k]]) l = lo_q[k];
                    ng = '0; ng[l] = 1'b1;
                end else begin
                    ng = '0; ng[h] = 1'b1;
                end
            end
            st = (m_st == 1) && bus_busy && (exp_gnt != '0);
            if (st) begin
                for (int i = 0; i < N; i++) begin
                    if (exp_gnt[i]) begin
                        starts[i]++;
                        if (grp_low[i]) begin
                            to_back(hi_q, N);
                            to_back(lo_q, i);
                        end else begin
                            to_back(hi_q, i);
                        end
                    end
                end
            end
            m_st = (m_dis != 0) ? 0 : (bus_busy ? 2 : 1);
            if (cfg_we) m_dis = cfg_dis ? 1 : 0;
            exp_gnt = ng;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        chk(gnt == exp_gnt, cur_req, int'(gnt), int'(exp_gnt));
        chk($onehot0(gnt), "R2", int'(gnt), 0);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xact(input int len);
        bus_busy = 1'b1;
        tick(len);
        bus_busy = 1'b0;
        tick(1);
    endtask

    task automatic clr_starts();
        for (int i = 0; i < N; i++) starts[i] = 0;
    endtask

    initial begin
        logic [N-1:0] g0;
        clr_starts();
        tick(3);
        chk(gnt == '0, "R1", int'(gnt), 0);
        rst_n = 1'b1;
        req = '1;
        tick(4);
        chk(gnt == '0, "R1", int'(gnt), 0);
        // switch on
        cfg_we = 1'b1; cfg_dis = 1'b0;
        tick(1);
        cfg_we = 1'b0;
        chk(gnt == '0, "R1", int'(gnt), 0);
        tick(1);
        chk(gnt == 4'b0001, "R6", int'(gnt), 1);

        // all favoured: plain LRU plus hidden handover
        cur_req = "R6";
        clr_starts();
        g0 = gnt;
        bus_busy = 1'b1;
        tick(2);
        chk(bus_busy && gnt != g0, "R4", int'(gnt), int'(g0));
        bus_busy = 1'b0;
        tick(1);
        for (int t = 0; t < 7; t++) xact(3);
        for (int i = 0; i < N; i++) chk(starts[i] == 2, "R11", starts[i], 2);

        // parking
        cur_req = "R3";
        req = '0;
        tick(5);
        chk(gnt != '0, "R3", int'(gnt), int'(exp_gnt));
        xact(2);

        // two favoured, two background
        cur_req = "R7";
        grp_low = 4'b1100;
        req = '1;
        tick(2);
        clr_starts();
        for (int t = 0; t < 12; t++) xact(2);
        chk(starts[0] == 4, "R8", starts[0], 4);
        chk(starts[1] == 4, "R8", starts[1], 4);
        chk(starts[2] == 2, "R8", starts[2], 2);
        chk(starts[3] == 2, "R8", starts[3], 2);

        // single background master
        cur_req = "R11";
        grp_low = 4'b0001;
        tick(2);
        clr_starts();
        for (int t = 0; t < 8; t++) xact(2);
        for (int i = 0; i < N; i++) chk(starts[i] == 2, "R11", starts[i], 2);

        // all background
        grp_low = 4'b1111;
        tick(2);
        clr_starts();
        for (int t = 0; t < 8; t++) xact(1);
        for (int i = 0; i < N; i++) chk(starts[i] == 2, "R11", starts[i], 2);

        // requests arriving on the start cycle, long busy with many handovers
        cur_req = "R5";
        grp_low = 4'b0110;
        req = 4'b0001;
        tick(2);
        bus_busy = 1'b1;
        req = 4'b1111;
        tick(1);
        req = 4'b0100;
        tick(1);
        req = 4'b1010;
        tick(3);
        bus_busy = 1'b0;
        tick(1);
        for (int t = 0; t < 4; t++) xact(2);

        // regrouping mid-transfer
        cur_req = "R9";
        req = '1;
        bus_busy = 1'b1;
        tick(1);
        grp_low = 4'b1001;
        tick(1);
        grp_low = 4'b0011;
        tick(2);
        bus_busy = 1'b0;
        tick(1);
        for (int t = 0; t < 6; t++) xact(2);

        // switch off
        cur_req = "R10";
        cfg_we = 1'b1; cfg_dis = 1'b1;
        tick(1);
        cfg_we = 1'b0;
        tick(1);
        chk(gnt == '0, "R10", int'(gnt), 0);
        xact(2);
        chk(gnt == '0, "R10", int'(gnt), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule